// File: doc/BRIEF.md
# DRAM Cycle Sequencer with Refresh

This block sequences one DRAM array through one memory cycle at a time. Each cycle is a run of numbered one-clock states, S0 upward. The cycle is picked from a write/read flag and a 3-bit length code, and can be one of these:

- a full write
- a read-modify-write (partial write)
- an 8-, 16- or 32-byte read; the longer reads add nibble-mode column accesses
- a refresh in which the column strobe comes before the row strobe

For every state the block drives the row strobe, the column strobe, the write strobe and two correction-unit mode lines. It also drives a strobe that tells the read pipeline to capture corrected data, a merge-enable for the read-modify-write, and a 4-bit byte-lane mask.

The sequencer is idle in S0. A command is taken on a clock edge where `cmd_valid` and `ready` are both high, and S1 follows on the next state. A read's final state also serves as S0 of the next cycle, so reads can run back to back with no idle clock between them.

A free-running interval timer raises a refresh request. While the request is pending, `ready` stays low and the refresh runs at the first point where a new cycle could begin.

Top module: `dram_cycle_seq`

## Requirements
- R1: While reset is high, and on the first sample after reset, all strobe outputs and `byte_sel` are 0, `ready` is 1 and no refresh is pending.
- R2: A write (`cmd_write`=1, `cmd_len` 0, 4, 5, 6 or 7) occupies S0–S4. The row strobe is high in S1–S3, the column strobe in S2–S3 and the write strobe in S3 only. Both correction mode lines stay low. `byte_sel` is 4'b1111, and `ready` is 1 again in the idle state after S4.
- R3: A write with `cmd_len` 1, 2 or 3 is a partial write, occupying S0–S8. Row strobe S1–S7, column strobe S2–S7, detect line S2–S5, correct line S4–S5, merge S6–S7, write strobe S7 only. `byte_sel` bit i (lane i, bit 0 = lane 0) is 1 exactly when `cmd_addr` ≤ i < `cmd_addr`+`cmd_len`; lanes above 3 are dropped.
- R4: A read (`cmd_write`=0) with `cmd_len` 5, or any code other than 6 and 7, is an 8-byte read over S0–S5. Row strobe S1–S3, column strobe S2–S3, detect S2–S5, correct S4–S5, capture S5. `ready` is 1 in S5, and a command taken there shows its S1 on the next state.
- R5: A read with `cmd_len` 6 ends at S8, and one with 7 ends at S14. The column strobe is high in pairs starting at S2, S5, S8 and S11, and the row strobe stays high from S1 to two states before the end. Detect runs from S2 to the end. Correct is high in the pair of states starting at S4, S7, S10 and S13, and capture is high at S5, S8, S11 and S14, each limited to the read's length.
- R6: A refresh occupies S0–S5. The column strobe is high in S1–S2 and the row strobe in S2–S4. Write, mode, capture and merge stay low, and `byte_sel` is 0.
- R7: A refresh request becomes pending on every REF_INTERVAL-th clock edge after reset is released and stays pending until the refresh reaches S3. While it is pending, `ready` is 0.
- R8: A pending refresh starts its S1 on the next edge when the array is idle, or directly after a read's final state. After a write or partial write it starts after one idle state. `ready` stays 0 until the refresh is over.
- R9: A command offered while `ready` is 0 is dropped and has no effect on the cycle that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered this cycle |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_len | input | 3 | Length code selecting the cycle type |
| cmd_addr | input | 2 | Low byte address of the access |
| ready | output | 1 | Command accepted on this edge if `cmd_valid` is high |
| ras | output | 1 | Row address strobe (active high) |
| cas | output | 1 | Column address strobe (active high) |
| we | output | 1 | Write strobe (active high) |
| edac_s1 | output | 1 | Correction unit detect-mode line |
| edac_s0 | output | 1 | Correction unit correct-mode line |
| rd_capture | output | 1 | Corrected read data is captured at the end of this state |
| merge_en | output | 1 | Merged word driven to the array (partial write) |
| byte_sel | output | 4 | Byte lanes written by the current cycle |

## Verification
A command taken at an edge shows S1 on the strobes at the very next sample, and state Sn appears n samples after the accepting edge. The bench therefore checks every state of every cycle at the negedge sample with that index. A refresh request set on edge N drops `ready` at the sample after edge N, and from idle the refresh S1 appears one sample later. The bench keeps its own count of edges since reset, so it knows which samples a refresh can reach. Command sweeps are issued only in windows that no refresh can reach, and the deferral tests are placed so that the timer fires at a known state inside a long read or a write.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;
  localparam int LANES  = 4;
  localparam int ADDR_W = $clog2(LANES);
  localparam int LEN_W  = 3;
  localparam int STEP_W = 4;

  typedef enum logic [2:0] {
    CYC_IDLE, CYC_WR, CYC_PW, CYC_RD8, CYC_RD16, CYC_RD32, CYC_REF
  } cyc_e;

  typedef struct packed {
    logic ras;
    logic cas;
    logic we;
    logic det;
    logic cor;
    logic cap;
    logic mrg;
  } strobe_t;

  function automatic logic [STEP_W-1:0] final_step(cyc_e k);
    case (k)
      CYC_WR:   return STEP_W'(4);
      CYC_PW:   return STEP_W'(8);
      CYC_RD8:  return STEP_W'(5);
      CYC_RD16: return STEP_W'(8);
      CYC_RD32: return STEP_W'(14);
      CYC_REF:  return STEP_W'(5);
      default:  return STEP_W'(0);
    endcase
  endfunction

  function automatic logic is_read(cyc_e k);
    return (k == CYC_RD8) || (k == CYC_RD16) || (k == CYC_RD32);
  endfunction
endpackage

// File: rtl/dram_seq_refresh_timer.sv
module dram_seq_refresh_timer #(
  parameter int INTERVAL = 312
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  output logic pend
);
  localparam int CW = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;
  localparam logic [CW-1:0] WRAP = CW'(INTERVAL - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      pend  <= 1'b0;
    end else if (cnt_q == WRAP) begin
      cnt_q <= '0;
      pend  <= 1'b1;
    end else begin
      cnt_q <= cnt_q + CW'(1);
      if (clear) pend <= 1'b0;
    end
  end
endmodule

// File: rtl/dram_seq_cmd_decode.sv
module dram_seq_cmd_decode
  import dram_seq_pkg::*;
(
  input  logic              wr,
  input  logic [LEN_W-1:0]  len,
  input  logic [ADDR_W-1:0] addr,
  output cyc_e              kind,
  output logic [LANES-1:0]  bsel
);
  logic short_wr;
  logic [LANES-1:0] lane_hit;

  assign short_wr = wr && (len inside {3'd1, 3'd2, 3'd3});

  always_comb begin
    if (wr)                kind = short_wr ? CYC_PW : CYC_WR;
    else if (len == 3'd6)  kind = CYC_RD16;
    else if (len == 3'd7)  kind = CYC_RD32;
    else                   kind = CYC_RD8;
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_hit[i] = (i >= int'(addr)) && (i < int'(addr) + int'(len));
  end

  assign bsel = short_wr ? lane_hit : '1;
endmodule

// File: rtl/dram_seq_strobe_decode.sv
module dram_seq_strobe_decode
  import dram_seq_pkg::*;
(
  input  cyc_e              kind,
  input  logic [STEP_W-1:0] step,
  output strobe_t           strb
);
  int n;
  int lst;

  always_comb begin
    n    = int'(step);
    lst  = int'(final_step(kind));
    strb = '0;
    case (kind)
      CYC_WR: begin
        strb.ras = (n >= 1) && (n <= 3);
        strb.cas = (n >= 2) && (n <= 3);
        strb.we  = (n == 3);
      end
      CYC_PW: begin
        strb.ras = (n >= 1) && (n <= 7);
        strb.cas = (n >= 2) && (n <= 7);
        strb.det = (n >= 2) && (n <= 5);
        strb.cor = (n >= 4) && (n <= 5);
        strb.mrg = (n >= 6) && (n <= 7);
        strb.we  = (n == 7);
      end
      CYC_RD8, CYC_RD16, CYC_RD32: begin
        strb.ras = (n >= 1) && (n <= lst - 2);
        strb.cas = (n >= 2) && (n <= lst - 2) && (n % 3 != 1);
        strb.det = (n >= 2) && (n <= lst);
        strb.cor = (n >= 4) && (n <= lst) && (n % 3 != 0);
        strb.cap = (n >= 5) && (n <= lst) && (n % 3 == 2);
      end
      CYC_REF: begin
        strb.cas = (n >= 1) && (n <= 2);
        strb.ras = (n >= 2) && (n <= 4);
      end
      default: strb = '0;
    endcase
  end
endmodule

// File: rtl/dram_cycle_seq.sv
module dram_cycle_seq
  import dram_seq_pkg::*;
#(
  parameter int REF_INTERVAL = 312
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic              cmd_write,
  input  logic [LEN_W-1:0]  cmd_len,
  input  logic [ADDR_W-1:0] cmd_addr,
  output logic              ready,
  output logic              ras,
  output logic              cas,
  output logic              we,
  output logic              edac_s1,
  output logic              edac_s0,
  output logic              rd_capture,
  output logic              merge_en,
  output logic [LANES-1:0]  byte_sel
);
  cyc_e              kind_q, kind_d, dec_kind;
  logic [STEP_W-1:0] step_q, step_d;
  logic [LANES-1:0]  bsel_q, bsel_d, dec_bsel;
  strobe_t           strb_q, strb_d;
  logic              ref_pend_q, ref_clear;
  logic              at_end, can_start;

  dram_seq_refresh_timer #(.INTERVAL(REF_INTERVAL)) timer_i (
    .clk(clk), .rst(rst), .clear(ref_clear), .pend(ref_pend_q)
  );

  dram_seq_cmd_decode dec_i (
    .wr(cmd_write), .len(cmd_len), .addr(cmd_addr),
    .kind(dec_kind), .bsel(dec_bsel)
  );

  dram_seq_strobe_decode strb_i (
    .kind(kind_d), .step(step_d), .strb(strb_d)
  );

  assign ref_clear = (kind_q == CYC_REF) && (step_q == STEP_W'(2));
  assign at_end    = (kind_q != CYC_IDLE) && (step_q == final_step(kind_q));
  assign can_start = (kind_q == CYC_IDLE) || (at_end && is_read(kind_q));
  assign ready     = can_start && !ref_pend_q;

  always_comb begin
    kind_d = kind_q;
    step_d = step_q + STEP_W'(1);
    bsel_d = bsel_q;
    if (can_start && ref_pend_q) begin
      kind_d = CYC_REF;
      step_d = STEP_W'(1);
      bsel_d = '0;
    end else if (can_start && cmd_valid) begin
      kind_d = dec_kind;
      step_d = STEP_W'(1);
      bsel_d = dec_bsel;
    end else if (at_end || kind_q == CYC_IDLE) begin
      kind_d = CYC_IDLE;
      step_d = '0;
      bsel_d = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      kind_q <= CYC_IDLE;
      step_q <= '0;
      bsel_q <= '0;
      strb_q <= '0;
    end else begin
      kind_q <= kind_d;
      step_q <= step_d;
      bsel_q <= bsel_d;
      strb_q <= strb_d;
    end
  end

  assign ras        = strb_q.ras;
  assign cas        = strb_q.cas;
  assign we         = strb_q.we;
  assign edac_s1    = strb_q.det;
  assign edac_s0    = strb_q.cor;
  assign rd_capture = strb_q.cap;
  assign merge_en   = strb_q.mrg;
  assign byte_sel   = bsel_q;
endmodule

// File: rtl/dram_cycle_seq_chk.sv
module dram_cycle_seq_chk (
  input logic clk,
  input logic rst,
  input logic ready,
  input logic ras,
  input logic cas,
  input logic we,
  input logic edac_s1,
  input logic edac_s0,
  input logic rd_capture,
  input logic ref_pend_q
);
  // R2, R3: writing happens only inside an open row and column
  a_r2_we_in_open_page: assert property (@(posedge clk) disable iff (rst)
    we |-> (ras && cas));

  // R2, R3: check bits are generated while writing, so both mode lines are low
  a_r2_we_generate_mode: assert property (@(posedge clk) disable iff (rst)
    we |-> (!edac_s1 && !edac_s0));

  // R3: the write strobe is one clock wide
  a_r3_we_single_clock: assert property (@(posedge clk) disable iff (rst)
    we |=> !we);

  // R4, R5: data is captured only while the unit is correcting
  a_r4_capture_when_correcting: assert property (@(posedge clk) disable iff (rst)
    rd_capture |-> (edac_s0 && edac_s1));

  // R6: a row strobe that rises under a column strobe had that column strobe already
  a_r6_cas_before_ras: assert property (@(posedge clk) disable iff (rst)
    ($rose(ras) && cas) |-> $past(cas));

  // R7: no command is accepted while a refresh is pending
  a_r7_pending_blocks_ready: assert property (@(posedge clk) disable iff (rst)
    ref_pend_q |-> !ready);

  // R7: the request drops in refresh S3 (row high, column low)
  a_r7_clear_in_s3: assert property (@(posedge clk) disable iff (rst)
    $fell(ref_pend_q) |-> (ras && !cas));
endmodule

bind dram_cycle_seq dram_cycle_seq_chk chk_i (
  .clk(clk), .rst(rst), .ready(ready), .ras(ras), .cas(cas), .we(we),
  .edac_s1(edac_s1), .edac_s0(edac_s0), .rd_capture(rd_capture),
  .ref_pend_q(ref_pend_q)
);

// File: tb/dram_cycle_seq_tb_top.sv
module dram_cycle_seq_tb_top;
  localparam int INTV = 100;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmd_valid = 1'b0;
  logic       cmd_write = 1'b0;
  logic [2:0] cmd_len = 3'd0;
  logic [1:0] cmd_addr = 2'd0;
  logic       ready, ras, cas, we, edac_s1, edac_s0, rd_capture, merge_en;
  logic [3:0] byte_sel;

  int errs = 0;
  int checks = 0;
  int cyc = 0;
  bit done = 0;

  always #10 clk = ~clk;

  always @(posedge clk) begin
    if (rst) cyc <= 0;
    else     cyc <= cyc + 1;
  end

  dram_cycle_seq #(.REF_INTERVAL(INTV)) dut_i (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
    .cmd_len(cmd_len), .cmd_addr(cmd_addr), .ready(ready), .ras(ras),
    .cas(cas), .we(we), .edac_s1(edac_s1), .edac_s0(edac_s0),
    .rd_capture(rd_capture), .merge_en(merge_en), .byte_sel(byte_sel)
  );

  // kinds: 1 write, 2 partial write, 3 read8, 4 read16, 5 read32, 6 refresh
  function automatic int last_of(int k);
    case (k)
      1: return 4;
      2: return 8;
      3: return 5;
      4: return 8;
      5: return 14;
      default: return 5;
    endcase
  endfunction

  function automatic logic [6:0] exp_pat(int k, int s);
    logic r, c, w, d, x, p, m;
    {r, c, w, d, x, p, m} = 7'b0;
    case (k)
      1: begin r = s inside {[1:3]}; c = s inside {2, 3}; w = (s == 3); end
      2: begin
        r = s inside {[1:7]}; c = s inside {[2:7]}; d = s inside {[2:5]};
        x = s inside {4, 5}; m = s inside {6, 7}; w = (s == 7);
      end
      3: begin
        r = s inside {[1:3]}; c = s inside {2, 3}; d = s inside {[2:5]};
        x = s inside {4, 5}; p = (s == 5);
      end
      4: begin
        r = s inside {[1:6]}; c = s inside {2, 3, 5, 6}; d = s inside {[2:8]};
        x = s inside {4, 5, 7, 8}; p = s inside {5, 8};
      end
      5: begin
        r = s inside {[1:12]}; c = s inside {2, 3, 5, 6, 8, 9, 11, 12};
        d = s inside {[2:14]}; x = s inside {4, 5, 7, 8, 10, 11, 13, 14};
        p = s inside {5, 8, 11, 14};
      end
      6: begin c = s inside {1, 2}; r = s inside {[2:4]}; end
      default: ;
    endcase
    return {r, c, w, d, x, p, m};
  endfunction

  function automatic logic [6:0] obs();
    return {ras, cas, we, edac_s1, edac_s0, rd_capture, merge_en};
  endfunction

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic check_idle(string req, bit exp_rdy);
    chk(obs() == 7'b0, req, "idle strobes", 32'(obs()), 0);
    chk(ready == exp_rdy, req, "idle ready", 32'(ready), 32'(exp_rdy));
  endtask

  // wait at negedges until ready and no refresh tick can reach the next span states
  task automatic wait_slot(int span);
    while (!(ready && (INTV - (cyc % INTV)) > span + 2)) @(negedge clk);
  endtask

  // called at a negedge with ready high; checks S1..Slast, returns at Slast sample
  task automatic run_cmd(bit wr, logic [2:0] len, logic [1:0] addr, int k,
                         logic [3:0] exp_bs, bit exp_rdy_last, string req);
    int lst;
    bit er;
    lst = last_of(k);
    cmd_valid = 1'b1; cmd_write = wr; cmd_len = len; cmd_addr = addr;
    @(negedge clk);
    cmd_valid = 1'b0;
    for (int s = 1; s <= lst; s++) begin
      if (s > 1) @(negedge clk);
      chk(obs() == exp_pat(k, s), req, $sformatf("strobes kind%0d S%0d", k, s),
          32'(obs()), 32'(exp_pat(k, s)));
      if (s == 1) chk(byte_sel == exp_bs, req, "byte_sel", 32'(byte_sel), 32'(exp_bs));
      er = (s == lst && k >= 3 && k <= 5) ? exp_rdy_last : 1'b0;
      chk(ready == er, req, $sformatf("ready S%0d", s), 32'(ready), 32'(er));
    end
  endtask

  task automatic check_refresh(string req);
    for (int s = 1; s <= 5; s++) begin
      @(negedge clk);
      chk(obs() == exp_pat(6, s), req, $sformatf("refresh S%0d", s), 32'(obs()), 32'(exp_pat(6, s)));
      chk(ready == 1'b0, req, "ready in refresh", 32'(ready), 0);
      chk(byte_sel == 4'h0, req, "refresh byte_sel", 32'(byte_sel), 0);
    end
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    int t1;
    logic [3:0] bs;
    int k;
    // R1: reset state, command offered during reset ignored
    cmd_valid = 1'b1; cmd_write = 1'b0; cmd_len = 3'd7;
    repeat (3) @(negedge clk);
    check_idle("R1", 1'b1);
    chk(byte_sel == 4'h0, "R1", "reset byte_sel", 32'(byte_sel), 0);
    cmd_valid = 1'b0;
    rst = 1'b0;
    @(negedge clk);
    check_idle("R1", 1'b1);

    // R2: full writes
    for (int l = 0; l < 8; l++) begin
      if (l >= 1 && l <= 3) continue;
      wait_slot(6);
      run_cmd(1'b1, 3'(l), 2'(l), 1, 4'hF, 1'b0, "R2");
      @(negedge clk);
      check_idle("R2", 1'b1);
    end

    // R3: partial write sweep over address and length
    for (int a = 0; a < 4; a++) begin
      for (int l = 1; l <= 3; l++) begin
        bs = 4'(((1 << l) - 1) << a);
        wait_slot(10);
        run_cmd(1'b1, 3'(l), 2'(a), 2, bs, 1'b0, "R3");
        @(negedge clk);
        check_idle("R3", 1'b1);
      end
    end

    // R4, R5: every read length code
    for (int l = 0; l < 8; l++) begin
      k = (l == 6) ? 4 : (l == 7) ? 5 : 3;
      wait_slot(16);
      run_cmd(1'b0, 3'(l), 2'd0, k, 4'hF, 1'b1, (k == 3) ? "R4" : "R5");
      @(negedge clk);
      check_idle((k == 3) ? "R4" : "R5", 1'b1);
    end

    // R4: back to back, read final state doubles as next S0
    wait_slot(40);
    run_cmd(1'b0, 3'd5, 2'd0, 3, 4'hF, 1'b1, "R4");
    run_cmd(1'b0, 3'd7, 2'd0, 5, 4'hF, 1'b1, "R4");
    run_cmd(1'b0, 3'd6, 2'd0, 4, 4'hF, 1'b1, "R5");
    run_cmd(1'b1, 3'd2, 2'd1, 2, 4'b0110, 1'b0, "R4");
    @(negedge clk);
    check_idle("R4", 1'b1);

    // R9: a read offered during a write is dropped
    wait_slot(8);
    cmd_valid = 1'b1; cmd_write = 1'b1; cmd_len = 3'd4; cmd_addr = 2'd0;
    @(negedge clk);
    cmd_write = 1'b0; cmd_len = 3'd7;
    repeat (3) @(negedge clk);
    cmd_valid = 1'b0;
    @(negedge clk);
    check_idle("R9", 1'b1);
    @(negedge clk);
    check_idle("R9", 1'b1);

    // R7, R8: refresh from idle
    while ((cyc % INTV) != 0) @(negedge clk);
    check_idle("R7", 1'b0);
    t1 = cyc;
    check_refresh("R6");
    @(negedge clk);
    check_idle("R6", 1'b1);
    // R7: next request arrives INTV edges later
    while (!(obs() == exp_pat(6, 1))) @(negedge clk);
    chk(cyc == t1 + INTV + 1, "R7", "refresh period", 32'(cyc), 32'(t1 + INTV + 1));
    for (int s = 2; s <= 6; s++) @(negedge clk);
    check_idle("R7", 1'b1);

    // R8: refresh deferred behind a 32-byte read, starts right after its final state
    while (!(ready && (INTV - (cyc % INTV)) == 5)) @(negedge clk);
    run_cmd(1'b0, 3'd7, 2'd0, 5, 4'hF, 1'b0, "R8");
    check_refresh("R8");
    @(negedge clk);
    check_idle("R8", 1'b1);

    // R8: refresh deferred behind a write, one idle state first
    while (!(ready && (INTV - (cyc % INTV)) == 3)) @(negedge clk);
    run_cmd(1'b1, 3'd4, 2'd0, 1, 4'hF, 1'b0, "R8");
    @(negedge clk);
    check_idle("R8", 1'b0);
    check_refresh("R8");
    @(negedge clk);
    check_idle("R8", 1'b1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule